// File: doc/BRIEF.md
# TDM Slot Mask Controller

This block sits between a register bus and the per-slot control of a time-division-multiplexed serial transmitter and receiver in network mode. Software programs a 32-bit transmit mask and a 32-bit receive mask, each split over two 24-bit bus registers. At every slot boundary the block looks up the bit for the slot that is starting. It then decides whether the transmitter drives a word or releases its data pins, whether a transmit-empty request is raised, and whether the external transmit buffer enable is asserted. When the serial side reports a finished word, the receive bit of the current slot decides whether that word is kept and the receive-full flag set, or whether it is dropped.

A write-only null-data register gives one-shot muting. A write to it turns the next slot that starts into a silent slot. In that slot the data pins float and the buffer enable stays low, whatever the mask says, and no transmit-empty request is raised. The serial shifter and the clock and frame-sync generators are outside the block. They appear only as a `slot_start` strobe with a `slot_idx` index and a `word_done` strobe with the received word.

The slot controller is a four-state machine. `ST_WAIT` is the state after reset, before the first slot, and the transmitter is released. `ST_LIVE` is a slot that drives data. `ST_MUTE` is a slot whose transmit mask bit is clear. `ST_NULL` is a slot taken by a pending null-data write. There is one transition rule: on `slot_start` any state goes to `ST_NULL` if a null write is pending, otherwise to `ST_LIVE` if the mask bit of `slot_idx` is set, otherwise to `ST_MUTE`. Without `slot_start` the state holds. Only reset returns the machine to `ST_WAIT`.

Top module: `tdm_slot_gate`

## Requirements
- R1: After reset both masks read as zero, `tx_drive`, `ext_buf_en`, `tx_empty` and `rx_full` are 0, and the transmitter stays released until the first `slot_start`.
- R2: Register map on `bus_addr`: 0 holds transmit slots 0–15, 1 holds transmit slots 16–31, 2 holds receive slots 0–15, and 3 holds receive slots 16–31. In each register, bit k controls the k-th slot of its half, in bits 15:0. Reads of these registers return the written bits 15:0, and bits 23:16 always read 0. Reads of addresses 4, 5 and 7 return 0.
- R3: On a `slot_start` with the transmit mask bit of `slot_idx` set and no null write pending, `tx_drive` is 1 from the next cycle until the next `slot_start`, and `tx_empty` is set at the same edge. `tx_word` shows the last word written to address 5.
- R4: On a `slot_start` with the transmit mask bit clear, `tx_drive` is 0 for that slot and `tx_empty` is not set.
- R5: A `word_done` inside a slot whose receive mask bit was set at that slot's start stores `rx_word` and sets `rx_full`. A read of address 6 returns the stored word.
- R6: A `word_done` in a slot whose receive bit was clear, or before the first slot, leaves `rx_full` and the word read at address 6 unchanged.
- R7: A write to address 4 (null data) makes the next slot to start a silent slot, with `tx_drive` and `ext_buf_en` at 0 and `tx_empty` not set, even if the mask bit is set. A null write in the same cycle as `slot_start` applies to the following slot. Each null write is used up by exactly one slot.
- R8: `ext_buf_en` is 1 only when `buf_en_cfg` is 1 and the current slot drives data. When `buf_en_cfg` is 0 it stays 0.
- R9: A write to address 5 clears `tx_empty`, and a read of address 6 clears `rx_full`. When a set condition and a clear condition fall in the same cycle, the set wins.
- R10: A mask write inside a slot does not change that slot's `tx_drive` or receive decision. A mask write in the same cycle as `slot_start` first affects the following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full on address 6) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data, combinational from `bus_addr` |
| buf_en_cfg | input | 1 | External buffer enable feature configured |
| slot_start | input | 1 | Strobe marking the start of slot `slot_idx` |
| slot_idx | input | 5 | Index of the slot that is starting |
| word_done | input | 1 | Strobe marking a received word |
| rx_word | input | 24 | Received word |
| tx_word | output | 24 | Word held in the transmit data register |
| tx_drive | output | 1 | 1 = drive data pins, 0 = high impedance |
| tx_empty | output | 1 | Transmit-empty request |
| ext_buf_en | output | 1 | External transmit buffer enable |
| rx_full | output | 1 | Receive-full flag |

## Verification
The bench targets collisions at a slot boundary. These include a null write or a mask write in the same cycle as `slot_start`, and a `tx_empty` set landing on a data write. A design that looked at post-write values would mute or enable the wrong slot, and a design with clear beating set would lose a request. It also writes all-ones patterns to the mask registers, so a design that stored or returned bits 23:16 would fail on readback. Mid-slot mask writes and `word_done` in a disabled or pre-first slot catch a design that decodes the mask continuously rather than latching it at the boundary. A null write left pending after its slot would show up as a second silent slot.

// File: rtl/tdm_slot_pkg.sv
`timescale 1ns/1ps
package tdm_slot_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LIVE = 2'd1,
        ST_MUTE = 2'd2,
        ST_NULL = 2'd3
    } slot_st_t;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_TXM_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_TXM_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RXM_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_RXM_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_NULL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_TXD    = 3'd5;
    localparam logic [ADDR_W-1:0] A_RXD    = 3'd6;
endpackage

// File: rtl/tdm_mask_regs.sv
`timescale 1ns/1ps
// Four half-mask registers; the register index equals its bus address.
module tdm_mask_regs #(
    parameter int SLOTS = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [tdm_slot_pkg::ADDR_W-1:0]  addr,
    input  logic [SLOTS/2-1:0]               wdata,
    output logic [SLOTS-1:0]                 tx_mask,
    output logic [SLOTS-1:0]                 rx_mask
);
    localparam int HALF  = SLOTS / 2;
    localparam int NREGS = 4;

    logic [HALF-1:0] half_q [NREGS];

    for (genvar h = 0; h < NREGS; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[h] <= '0;
            end else if (wr && (addr == h[tdm_slot_pkg::ADDR_W-1:0])) begin
                half_q[h] <= wdata;
            end
        end
    end

    assign tx_mask = {half_q[1], half_q[0]};
    assign rx_mask = {half_q[3], half_q[2]};
endmodule

// File: rtl/tdm_slot_fsm.sv
`timescale 1ns/1ps
module tdm_slot_fsm
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic [IDX_W-1:0] slot_idx,
    input  logic [SLOTS-1:0] tx_mask,
    input  logic [SLOTS-1:0] rx_mask,
    input  logic             null_wr,
    input  logic             txd_wr,
    input  logic             buf_en_cfg,
    output logic             tx_drive,
    output logic             tx_empty,
    output logic             ext_buf_en,
    output logic             rx_slot_en,
    output logic             null_pend
);
    slot_st_t state_q, state_d;
    logic     tx_bit;

    assign tx_bit = tx_mask[slot_idx];

    always_comb begin
        state_d = state_q;
        if (slot_start) begin
            if (null_pend)   state_d = ST_NULL;
            else if (tx_bit) state_d = ST_LIVE;
            else             state_d = ST_MUTE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        tx_drive = 1'b0;
        unique case (state_q)
            ST_WAIT: tx_drive = 1'b0;
            ST_LIVE: tx_drive = 1'b1;
            ST_MUTE: tx_drive = 1'b0;
            ST_NULL: tx_drive = 1'b0;
        endcase
        ext_buf_en = buf_en_cfg & tx_drive;
    end

    // one-shot null request, flags and per-slot receive decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            null_pend  <= 1'b0;
            tx_empty   <= 1'b0;
            rx_slot_en <= 1'b0;
        end else begin
            null_pend <= (null_pend & ~slot_start) | null_wr;
            if (slot_start && tx_bit && !null_pend) tx_empty <= 1'b1;
            else if (txd_wr)                         tx_empty <= 1'b0;
            if (slot_start) rx_slot_en <= rx_mask[slot_idx];
        end
    end
endmodule

// File: rtl/tdm_rx_capture.sv
`timescale 1ns/1ps
module tdm_rx_capture #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic              rx_slot_en,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rxd_rd,
    output logic [DATA_W-1:0] rx_hold,
    output logic              rx_full
);
    logic keep;
    assign keep = word_done & rx_slot_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
        end else begin
            if (keep) rx_hold <= rx_word;
            if (keep)        rx_full <= 1'b1;
            else if (rxd_rd) rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_slot_gate.sv
`timescale 1ns/1ps
module tdm_slot_gate
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int REG_W = 24,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int HALF  = SLOTS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              buf_en_cfg,
    input  logic              slot_start,
    input  logic [IDX_W-1:0]  slot_idx,
    input  logic              word_done,
    input  logic [REG_W-1:0]  rx_word,
    output logic [REG_W-1:0]  tx_word,
    output logic              tx_drive,
    output logic              tx_empty,
    output logic              ext_buf_en,
    output logic              rx_full
);
    localparam int PAD = REG_W - HALF;

    logic [SLOTS-1:0] tx_mask, rx_mask;
    logic [REG_W-1:0] rx_hold;
    logic             rx_slot_en, null_pend;
    logic             null_wr, txd_wr, rxd_rd;

    assign null_wr = bus_wr && (bus_addr == A_NULL);
    assign txd_wr  = bus_wr && (bus_addr == A_TXD);
    assign rxd_rd  = bus_rd && (bus_addr == A_RXD);

    tdm_mask_regs #(.SLOTS(SLOTS)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[HALF-1:0]),
        .tx_mask (tx_mask),
        .rx_mask (rx_mask)
    );

    tdm_slot_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .slot_idx   (slot_idx),
        .tx_mask    (tx_mask),
        .rx_mask    (rx_mask),
        .null_wr    (null_wr),
        .txd_wr     (txd_wr),
        .buf_en_cfg (buf_en_cfg),
        .tx_drive   (tx_drive),
        .tx_empty   (tx_empty),
        .ext_buf_en (ext_buf_en),
        .rx_slot_en (rx_slot_en),
        .null_pend  (null_pend)
    );

    tdm_rx_capture #(.DATA_W(REG_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_done  (word_done),
        .rx_slot_en (rx_slot_en),
        .rx_word    (rx_word),
        .rxd_rd     (rxd_rd),
        .rx_hold    (rx_hold),
        .rx_full    (rx_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      tx_word <= '0;
        else if (txd_wr) tx_word <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_TXM_LO: bus_rdata = {{PAD{1'b0}}, tx_mask[HALF-1:0]};
            A_TXM_HI: bus_rdata = {{PAD{1'b0}}, tx_mask[SLOTS-1:HALF]};
            A_RXM_LO: bus_rdata = {{PAD{1'b0}}, rx_mask[HALF-1:0]};
            A_RXM_HI: bus_rdata = {{PAD{1'b0}}, rx_mask[SLOTS-1:HALF]};
            A_RXD:    bus_rdata = rx_hold;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tdm_slot_gate_chk.sv
`timescale 1ns/1ps
module tdm_slot_gate_chk #(
    parameter int SLOTS = 32,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic             slot_start,
    input logic [IDX_W-1:0] slot_idx,
    input logic             word_done,
    input logic [SLOTS-1:0] tx_mask,
    input logic             null_pend,
    input logic             rx_slot_en,
    input logic             tx_drive,
    input logic             tx_empty,
    input logic             ext_buf_en,
    input logic             buf_en_cfg,
    input logic             rx_full
);
    p_live_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && tx_mask[slot_idx] && !null_pend) |=> (tx_drive && tx_empty));

    p_masked_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !tx_mask[slot_idx]) |=> !tx_drive);

    p_rx_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rx_slot_en) |=> rx_full);

    p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !rx_slot_en && !(bus_rd && bus_addr == 3'd6)) |=> $stable(rx_full));

    p_null_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && null_pend) |=> (!tx_drive && !ext_buf_en));

    p_buf_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en_cfg) |-> !ext_buf_en);

    p_txe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd5 && !slot_start) |=> !tx_empty);

    p_mid_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_start) |=> $stable(tx_drive));
endmodule

bind tdm_slot_gate tdm_slot_gate_chk #(.SLOTS(SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .slot_start (slot_start),
    .slot_idx   (slot_idx),
    .word_done  (word_done),
    .tx_mask    (tx_mask),
    .null_pend  (null_pend),
    .rx_slot_en (rx_slot_en),
    .tx_drive   (tx_drive),
    .tx_empty   (tx_empty),
    .ext_buf_en (ext_buf_en),
    .buf_en_cfg (buf_en_cfg),
    .rx_full    (rx_full)
);

// File: tb/tdm_slot_gate_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd, buf_en_cfg, slot_start, word_done;
    logic [2:0]  bus_addr;
    logic [23:0] bus_wdata, bus_rdata, rx_word, tx_word;
    logic [4:0]  slot_idx;
    logic        tx_drive, tx_empty, ext_buf_en, rx_full;

    always #2 clk = ~clk;

    tdm_slot_gate dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .buf_en_cfg(buf_en_cfg), .slot_start(slot_start), .slot_idx(slot_idx),
        .word_done(word_done), .rx_word(rx_word), .tx_word(tx_word),
        .tx_drive(tx_drive), .tx_empty(tx_empty), .ext_buf_en(ext_buf_en),
        .rx_full(rx_full)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [31:0] m_tx, m_rx;
    logic [23:0] m_hold, m_txw;
    logic        m_null, m_in, m_sl_tx, m_sl_null, m_sl_rx, m_txe, m_rxf;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {8'h00, m_tx[15:0]};
            3'd1:    return {8'h00, m_tx[31:16]};
            3'd2:    return {8'h00, m_rx[15:0]};
            3'd3:    return {8'h00, m_rx[31:16]};
            3'd6:    return m_hold;
            default: return 24'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        if (a == 3'd6) return "R5";
        return "R2";
    endfunction

    task automatic check_outs();
        logic d;
        d = m_in & m_sl_tx;
        chk(m_sl_null ? "R7" : (d ? "R3" : "R4"), tx_drive, d);
        chk("R8", ext_buf_en, buf_en_cfg & d);
        chk("R3 R9", tx_empty, m_txe);
        chk("R5 R6 R9", rx_full, m_rxf);
        chk("R3", tx_word, m_txw);
    endtask

    // one cycle: drive at negedge, model the edge, check at next negedge
    task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                        input logic [23:0] wd, input logic ss, input logic [4:0] idx,
                        input logic wdn, input logic [23:0] rw, input logic cfg);
        logic cap;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        slot_start = ss; slot_idx = idx; word_done = wdn; rx_word = rw; buf_en_cfg = cfg;
        #1;
        if (rd) chk(read_tag(a), bus_rdata, exp_read(a));
        cap = wdn & m_sl_rx;
        if (cap) m_hold = rw;
        if (cap) m_rxf = 1'b1;
        else if (rd && a == 3'd6) m_rxf = 1'b0;
        if (ss && m_tx[idx] && !m_null) m_txe = 1'b1;
        else if (wr && a == 3'd5) m_txe = 1'b0;
        if (ss) begin
            m_in = 1'b1; m_sl_tx = m_tx[idx] & ~m_null;
            m_sl_null = m_null; m_sl_rx = m_rx[idx];
        end
        m_null = (m_null & ~ss) | (wr && a == 3'd4);
        if (wr) begin
            case (a)
                3'd0: m_tx[15:0]  = wd[15:0];
                3'd1: m_tx[31:16] = wd[15:0];
                3'd2: m_rx[15:0]  = wd[15:0];
                3'd3: m_rx[31:16] = wd[15:0];
                3'd5: m_txw       = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check_outs();
    endtask

    task automatic idle(input logic cfg);
        step(1'b0, 1'b0, 3'd7, 24'h0, 1'b0, 5'd0, 1'b0, 24'h0, cfg);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [23:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 5'd0, 1'b0, 24'h0, 1'b1);
    endtask

    task automatic rd_reg(input logic [2:0] a);
        step(1'b0, 1'b1, a, 24'h0, 1'b0, 5'd0, 1'b0, 24'h0, 1'b1);
    endtask

    task automatic slot(input logic [4:0] idx);
        step(1'b0, 1'b0, 3'd7, 24'h0, 1'b1, idx, 1'b0, 24'h0, 1'b1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5107_a11e));
        m_tx = '0; m_rx = '0; m_hold = '0; m_txw = '0; m_null = 0; m_in = 0;
        m_sl_tx = 0; m_sl_null = 0; m_sl_rx = 0; m_txe = 0; m_rxf = 0;
        rst_n = 1'b0;
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; buf_en_cfg = 1;
        slot_start = 0; slot_idx = 0; word_done = 0; rx_word = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", {tx_drive, ext_buf_en, tx_empty, rx_full}, 4'b0000);
        for (int a = 0; a < 4; a++) rd_reg(3'(a));
        // R2 reserved bits and placement
        wr_reg(3'd0, 24'hFF_A5A5); rd_reg(3'd0);
        chk("R2", bus_rdata, 24'h00_A5A5);
        wr_reg(3'd1, 24'hFF_8001); rd_reg(3'd1);
        wr_reg(3'd2, 24'hFF_FFFF); rd_reg(3'd2);
        wr_reg(3'd3, 24'h00_0000); rd_reg(3'd4); rd_reg(3'd5); rd_reg(3'd7);
        // R3 live slot 0, R9 clear by data write
        slot(5'd0);
        chk("R3", tx_drive, 1'b1);
        wr_reg(3'd5, 24'h12_3456);
        chk("R9", tx_empty, 1'b0);
        // R4 slot 1 is masked off
        slot(5'd1);
        chk("R4", tx_drive, 1'b0);
        // R10 mid-slot mask write does not change slot 1
        wr_reg(3'd0, 24'h00_A5A7);
        chk("R10", tx_drive, 1'b0);
        // R7 null write then slot 31 (bit set): silent, then normal again
        wr_reg(3'd4, 24'h0);
        slot(5'd31);
        chk("R7", {tx_drive, ext_buf_en}, 2'b00);
        slot(5'd31);
        chk("R7", tx_drive, 1'b1);
        // R7 null write coinciding with slot_start applies to the following slot
        step(1'b1, 1'b0, 3'd4, 24'h0, 1'b1, 5'd0, 1'b0, 24'h0, 1'b1);
        chk("R7", tx_drive, 1'b1);
        slot(5'd0);
        chk("R7", tx_drive, 1'b0);
        // R5 capture in receive-enabled slot 2
        slot(5'd2);
        step(1'b0, 1'b0, 3'd7, 24'h0, 1'b0, 5'd0, 1'b1, 24'hC0FFEE, 1'b1);
        chk("R5", rx_full, 1'b1);
        rd_reg(3'd6);
        chk("R9", rx_full, 1'b0);
        // R6 drop in slot 20 (receive bit clear)
        slot(5'd20);
        step(1'b0, 1'b0, 3'd7, 24'h0, 1'b0, 5'd0, 1'b1, 24'hBAD000, 1'b1);
        chk("R6", rx_full, 1'b0);
        rd_reg(3'd6);
        chk("R6", bus_rdata, 24'hC0FFEE);
        // R8 buffer enable off when not configured
        slot(5'd0);
        idle(1'b0);
        chk("R8", ext_buf_en, 1'b0);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic wr, rd, ss, wdn, cfg;
            logic [2:0] a;
            wr  = ($urandom_range(3) == 0);
            rd  = ($urandom_range(3) == 0);
            a   = 3'($urandom_range(7));
            ss  = ($urandom_range(5) == 0);
            wdn = ($urandom_range(3) == 0);
            cfg = ($urandom_range(7) != 0);
            step(wr, rd, a, 24'($urandom), ss, 5'($urandom_range(31)),
                 wdn, 24'($urandom), cfg);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule